// File: doc/BRIEF.md
# Parallel Port Floppy Pin Multiplexer

This block decides what the parallel-port pins of a chip carry. In normal mode the pins carry the parallel-port engine's outputs. In either of two floppy modes they carry the outputs of the floppy-disk controller instead. The first floppy mode places only the second drive's select and motor lines on the port pins. Its first drive keeps its select and motor lines on the dedicated floppy pins. The second floppy mode places both drives on the port pins and releases all the dedicated floppy outputs.

The mode comes from a 2-bit configuration field. An external override pin pair can force the mode. The decoded mode is registered, so every change takes effect one clock edge later as a single step. In floppy mode, host reads of the parallel-port register window return fixed values that look like an unplugged cable. The data location returns the byte last written to it. The parallel-port power-control bit has no effect on the floppy routing. The floppy input signals are taken from the port's status pins.

Top module: `ppfd_pinmux`

## Requirements
- R1: `active_mode` is 0 (normal) after reset. One clock edge after `cfg_mode` is seen with `ovr_en`=0, `active_mode` takes code 1 (floppy mode 1) for `cfg_mode`=01, code 2 (floppy mode 2) for 10, and code 0 for 00 or 11.
- R2: When `ovr_en`=1, the next `active_mode` is 2 if `ovr_fd`=1 and 0 if `ovr_fd`=0, whatever `cfg_mode` holds.
- R3: In normal mode, `port_out` equals `par_out`. `port_oe` equals `par_oe` when `pwr_on`=1 and is all zero when `pwr_on`=0. Every dedicated floppy output is enabled (`ded_oe` all ones).
- R4: In floppy mode, the floppy output bus drives the port pins with `port_out[k]`=`fd_out[k]` for k<10, and `port_out[11:10]`=0. `port_oe` is 0x0FF in mode 1 and 0x3FF in mode 2, independent of `pwr_on` and `par_oe`.
- R5: `ded_out` always equals `fd_out`. In mode 1 only the first drive's select (bit 8) and motor (bit 9) stay enabled, so `ded_oe`=0x300. In mode 2, `ded_oe`=0. The `fd_out` bit order is 0 write data, 1 density select, 2 head select, 3 write gate, 4 direction, 5 step, 6 drive-1 select, 7 drive-1 motor, 8 drive-0 select, 9 drive-0 motor.
- R6: A write (`reg_wr`=1, `reg_addr`=0) stores `reg_wdata` at the clock edge in any mode. The stored byte resets to 0. In floppy mode, a read of address 0 returns the stored byte. A write and a read in the same cycle return the previous byte. In normal mode, address 0 returns `port_din`.
- R7: Address 2 (control) returns 0x04 in floppy mode, which is strobe 0, auto-feed 0, init 1 and select-in 0 at bits 0, 1, 2 and 3. In normal mode it returns {4'b0, `port_ctl_in`}.
- R8: Address 1 (status) returns 0x48 in floppy mode. In normal mode it returns {`port_st_in`, 3'b000}, where the bits of `port_st_in` from 4 down to 0 are busy, acknowledge, paper-end, select and error. Address 3 always reads 0.
- R9: `fd_in` equals `port_st_in` in floppy mode and `ded_in` in normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Configured pin mode |
| ovr_en | input | 1 | External override active |
| ovr_fd | input | 1 | Override value: 1 floppy mode 2, 0 normal |
| pwr_on | input | 1 | Parallel-port power control |
| par_out | input | 12 | Parallel engine pin values (8 data, 4 control) |
| par_oe | input | 12 | Parallel engine pin enables |
| port_out | output | 12 | Port pin output values |
| port_oe | output | 12 | Port pin output enables |
| port_din | input | 8 | Port data pins as received |
| port_ctl_in | input | 4 | Port control pins as received |
| port_st_in | input | 5 | Port status pins as received |
| fd_out | input | 10 | Floppy controller outputs |
| fd_in | output | 5 | Floppy controller inputs, routed |
| ded_out | output | 10 | Dedicated floppy pin values |
| ded_oe | output | 10 | Dedicated floppy pin enables |
| ded_in | input | 5 | Dedicated floppy input pins |
| reg_addr | input | 2 | Register window address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| active_mode | output | 2 | Registered active mode |

## Verification
Two events can fall in the same cycle: a data write and a data read at address 0, and a mode change arriving while a register read is open. Random stimulus changes the mode, override and register strobes every cycle, so writes that overlap reads and reads on the edge of a mode switch occur often. A directed sequence also writes and reads the data location together in floppy mode. Each readback is judged against a bench model that holds the previous byte and the previous mode until the clock edge.

// File: rtl/ppfd_pkg.sv
package ppfd_pkg;

  typedef enum logic [1:0] {
    PM_NORMAL = 2'd0,
    PM_FD1    = 2'd1,
    PM_FD2    = 2'd2
  } pmode_e;

  localparam logic [1:0] CFG_FD1 = 2'b01;
  localparam logic [1:0] CFG_FD2 = 2'b10;

  localparam logic [1:0] RA_DATA = 2'd0;
  localparam logic [1:0] RA_STAT = 2'd1;
  localparam logic [1:0] RA_CTRL = 2'd2;

  // Unplugged-cable images returned in floppy mode
  localparam logic [7:0] RB_STAT_IDLE = 8'h48;
  localparam logic [7:0] RB_CTRL_IDLE = 8'h04;

  // Number of floppy outputs owned by the second drive pair position
  localparam int DRV0_LINES = 2;

endpackage

// File: rtl/ppfd_mode_dec.sv
module ppfd_mode_dec
  import ppfd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cfg_mode,
  input  logic       ovr_en,
  input  logic       ovr_fd,
  output pmode_e     mode_q
);

  pmode_e mode_d;
  logic   upd_en;

  always_comb begin
    if (ovr_en) begin
      mode_d = ovr_fd ? PM_FD2 : PM_NORMAL;
    end else begin
      case (cfg_mode)
        CFG_FD1: mode_d = PM_FD1;
        CFG_FD2: mode_d = PM_FD2;
        default: mode_d = PM_NORMAL;
      endcase
    end
    upd_en = (mode_d != mode_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= PM_NORMAL;
    end else if (upd_en) begin
      mode_q <= mode_d;
    end
  end

endmodule

// File: rtl/ppfd_readback.sv
module ppfd_readback
  import ppfd_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 4,
  parameter int SW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  pmode_e        mode,
  input  logic [1:0]    addr,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] din,
  input  logic [CW-1:0] ctl_in,
  input  logic [SW-1:0] st_in,
  output logic [DW-1:0] rdata
);

  localparam int STAT_PAD = DW - SW;
  localparam int CTRL_PAD = DW - CW;

  logic [DW-1:0] hold_q;
  logic [DW-1:0] hold_d;
  logic          hold_en;
  logic          fd_act;

  always_comb begin
    hold_en = wr && (addr == RA_DATA);
    hold_d  = wdata;
    fd_act  = (mode != PM_NORMAL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (hold_en) begin
      hold_q <= hold_d;
    end
  end

  always_comb begin
    case (addr)
      RA_DATA: rdata = fd_act ? hold_q : din;
      RA_STAT: rdata = fd_act ? RB_STAT_IDLE[DW-1:0] : {st_in, {STAT_PAD{1'b0}}};
      RA_CTRL: rdata = fd_act ? RB_CTRL_IDLE[DW-1:0] : {{CTRL_PAD{1'b0}}, ctl_in};
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/ppfd_pin_route.sv
module ppfd_pin_route
  import ppfd_pkg::*;
#(
  parameter int NPIN = 12,
  parameter int NFO  = 10,
  parameter int NFI  = 5
) (
  input  pmode_e          mode,
  input  logic            pwr_on,
  input  logic [NPIN-1:0] par_out,
  input  logic [NPIN-1:0] par_oe,
  input  logic [NFO-1:0]  fd_out,
  input  logic [NFI-1:0]  ded_in,
  input  logic [NFI-1:0]  st_in,
  output logic [NPIN-1:0] port_out,
  output logic [NPIN-1:0] port_oe,
  output logic [NFO-1:0]  ded_out,
  output logic [NFO-1:0]  ded_oe,
  output logic [NFI-1:0]  fd_in
);

  localparam int FD1_CNT = NFO - DRV0_LINES;

  logic is_norm;
  logic is_fd1;
  logic is_fd2;

  always_comb begin
    is_norm = (mode == PM_NORMAL);
    is_fd1  = (mode == PM_FD1);
    is_fd2  = (mode == PM_FD2);
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_port
    logic fd_val;
    logic fd_en;
    if (i < FD1_CNT) begin : g_shared
      always_comb begin
        fd_val = fd_out[i];
        fd_en  = 1'b1;
      end
    end else if (i < NFO) begin : g_drv0
      always_comb begin
        fd_val = fd_out[i];
        fd_en  = is_fd2;
      end
    end else begin : g_idle
      always_comb begin
        fd_val = 1'b0;
        fd_en  = 1'b0;
      end
    end
    always_comb begin
      port_out[i] = is_norm ? par_out[i] : fd_val;
      port_oe[i]  = is_norm ? (par_oe[i] & pwr_on) : fd_en;
    end
  end

  for (genvar j = 0; j < NFO; j++) begin : g_ded
    always_comb begin
      ded_out[j] = fd_out[j];
      if (j < FD1_CNT) begin
        ded_oe[j] = is_norm;
      end else begin
        ded_oe[j] = is_norm | is_fd1;
      end
    end
  end

  always_comb begin
    fd_in = is_norm ? ded_in : st_in;
  end

endmodule

// File: rtl/ppfd_pinmux.sv
module ppfd_pinmux
  import ppfd_pkg::*;
#(
  parameter int DW  = 8,
  parameter int CW  = 4,
  parameter int SW  = 5,
  parameter int NFO = 10,
  localparam int NPIN = DW + CW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      cfg_mode,
  input  logic            ovr_en,
  input  logic            ovr_fd,
  input  logic            pwr_on,
  input  logic [NPIN-1:0] par_out,
  input  logic [NPIN-1:0] par_oe,
  output logic [NPIN-1:0] port_out,
  output logic [NPIN-1:0] port_oe,
  input  logic [DW-1:0]   port_din,
  input  logic [CW-1:0]   port_ctl_in,
  input  logic [SW-1:0]   port_st_in,
  input  logic [NFO-1:0]  fd_out,
  output logic [SW-1:0]   fd_in,
  output logic [NFO-1:0]  ded_out,
  output logic [NFO-1:0]  ded_oe,
  input  logic [SW-1:0]   ded_in,
  input  logic [1:0]      reg_addr,
  input  logic            reg_wr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic [1:0]      active_mode
);

  pmode_e mode;

  ppfd_mode_dec u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_mode (cfg_mode),
    .ovr_en   (ovr_en),
    .ovr_fd   (ovr_fd),
    .mode_q   (mode)
  );

  ppfd_readback #(.DW(DW), .CW(CW), .SW(SW)) u_rb (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode   (mode),
    .addr   (reg_addr),
    .wr     (reg_wr),
    .wdata  (reg_wdata),
    .din    (port_din),
    .ctl_in (port_ctl_in),
    .st_in  (port_st_in),
    .rdata  (reg_rdata)
  );

  ppfd_pin_route #(.NPIN(NPIN), .NFO(NFO), .NFI(SW)) u_route (
    .mode     (mode),
    .pwr_on   (pwr_on),
    .par_out  (par_out),
    .par_oe   (par_oe),
    .fd_out   (fd_out),
    .ded_in   (ded_in),
    .st_in    (port_st_in),
    .port_out (port_out),
    .port_oe  (port_oe),
    .ded_out  (ded_out),
    .ded_oe   (ded_oe),
    .fd_in    (fd_in)
  );

  assign active_mode = mode;

endmodule

// File: rtl/ppfd_pinmux_chk.sv
module ppfd_pinmux_chk #(
  parameter int DW   = 8,
  parameter int NPIN = 12,
  parameter int NFO  = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      cfg_mode,
  input logic            ovr_en,
  input logic            ovr_fd,
  input logic            pwr_on,
  input logic [NPIN-1:0] port_oe,
  input logic [NFO-1:0]  ded_oe,
  input logic [1:0]      reg_addr,
  input logic            reg_wr,
  input logic [DW-1:0]   reg_wdata,
  input logic [DW-1:0]   reg_rdata,
  input logic [1:0]      active_mode
);

  AST_CFG_FD1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovr_en && cfg_mode == 2'b01) |=> (active_mode == 2'd1)); // R1

  AST_OVR_FD2: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_en && ovr_fd) |=> (active_mode == 2'd2)); // R2

  AST_PWR_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (active_mode == 2'd0 && !pwr_on) |-> (port_oe == '0)); // R3

  AST_FD_SHARED_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (active_mode != 2'd0) |-> (port_oe[7:0] == 8'hFF)); // R4

  AST_FD2_DED_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    (active_mode == 2'd2) |-> (ded_oe == '0)); // R5

  AST_FD1_DED_DRV0: assert property (@(posedge clk) disable iff (!rst_n)
    (active_mode == 2'd1) |-> (ded_oe == 10'h300)); // R5

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(reg_wr && reg_addr == 2'd0) && active_mode != 2'd0 && reg_addr == 2'd0)
      |-> (reg_rdata == $past(reg_wdata))); // R6

  AST_CTRL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (active_mode != 2'd0 && reg_addr == 2'd2) |-> (reg_rdata == 8'h04)); // R7

  AST_STAT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (active_mode != 2'd0 && reg_addr == 2'd1) |-> (reg_rdata == 8'h48)); // R8

endmodule

bind ppfd_pinmux ppfd_pinmux_chk #(.DW(DW), .NPIN(NPIN), .NFO(NFO)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_mode    (cfg_mode),
  .ovr_en      (ovr_en),
  .ovr_fd      (ovr_fd),
  .pwr_on      (pwr_on),
  .port_oe     (port_oe),
  .ded_oe      (ded_oe),
  .reg_addr    (reg_addr),
  .reg_wr      (reg_wr),
  .reg_wdata   (reg_wdata),
  .reg_rdata   (reg_rdata),
  .active_mode (active_mode)
);

// File: tb/ppfd_pinmux_bench.sv
`timescale 1ns/1ps
module ppfd_pinmux_bench;

  logic        clk;
  logic        rst_n;
  logic [1:0]  cfg_mode;
  logic        ovr_en, ovr_fd, pwr_on;
  logic [11:0] par_out, par_oe, port_out, port_oe;
  logic [7:0]  port_din;
  logic [3:0]  port_ctl_in;
  logic [4:0]  port_st_in;
  logic [9:0]  fd_out, ded_out, ded_oe;
  logic [4:0]  fd_in, ded_in;
  logic [1:0]  reg_addr;
  logic        reg_wr;
  logic [7:0]  reg_wdata, reg_rdata;
  logic [1:0]  active_mode;

  int n_chk;
  int n_err;
  logic [1:0] m_mode;
  logic [7:0] m_hold;

  ppfd_pinmux u_ppfd_pinmux (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .ovr_en(ovr_en), .ovr_fd(ovr_fd),
    .pwr_on(pwr_on), .par_out(par_out), .par_oe(par_oe), .port_out(port_out),
    .port_oe(port_oe), .port_din(port_din), .port_ctl_in(port_ctl_in),
    .port_st_in(port_st_in), .fd_out(fd_out), .fd_in(fd_in), .ded_out(ded_out),
    .ded_oe(ded_oe), .ded_in(ded_in), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .active_mode(active_mode)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] f_next_mode(input logic [1:0] cfg, input logic oe, input logic ofd);
    if (oe) return ofd ? 2'd2 : 2'd0;
    if (cfg == 2'b01) return 2'd1;
    if (cfg == 2'b10) return 2'd2;
    return 2'd0;
  endfunction

  function automatic logic [11:0] f_port_out(input logic [1:0] m);
    if (m == 2'd0) return par_out;
    return {2'b00, fd_out};
  endfunction

  function automatic logic [11:0] f_port_oe(input logic [1:0] m);
    if (m == 2'd0) return pwr_on ? par_oe : 12'h000;
    return (m == 2'd1) ? 12'h0FF : 12'h3FF;
  endfunction

  function automatic logic [9:0] f_ded_oe(input logic [1:0] m);
    if (m == 2'd0) return 10'h3FF;
    return (m == 2'd1) ? 10'h300 : 10'h000;
  endfunction

  function automatic logic [7:0] f_rdata(input logic [1:0] m, input logic [7:0] hold);
    case (reg_addr)
      2'd0: return (m != 2'd0) ? hold : port_din;
      2'd1: return (m != 2'd0) ? 8'h48 : {port_st_in, 3'b000};
      2'd2: return (m != 2'd0) ? 8'h04 : {4'b0000, port_ctl_in};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check_all();
    check("R1", "active_mode", {30'd0, active_mode}, {30'd0, m_mode});
    check(m_mode == 2'd0 ? "R3" : "R4", "port_out", {20'd0, port_out}, {20'd0, f_port_out(m_mode)});
    check(m_mode == 2'd0 ? "R3" : "R4", "port_oe", {20'd0, port_oe}, {20'd0, f_port_oe(m_mode)});
    check("R5", "ded_oe", {22'd0, ded_oe}, {22'd0, f_ded_oe(m_mode)});
    check("R5", "ded_out", {22'd0, ded_out}, {22'd0, fd_out});
    check("R9", "fd_in", {27'd0, fd_in}, {27'd0, (m_mode == 2'd0) ? ded_in : port_st_in});
    check(reg_addr == 2'd0 ? "R6" : (reg_addr == 2'd2 ? "R7" : "R8"), "reg_rdata",
          {24'd0, reg_rdata}, {24'd0, f_rdata(m_mode, m_hold)});
  endtask

  // Check at the settled point, then advance the model across the edge
  task automatic step();
    #2;
    check_all();
    @(posedge clk);
    if (reg_wr && reg_addr == 2'd0) m_hold = reg_wdata;
    m_mode = f_next_mode(cfg_mode, ovr_en, ovr_fd);
    @(negedge clk);
  endtask

  task automatic randomize_pins();
    par_out     = 12'($urandom);
    par_oe      = 12'($urandom);
    port_din    = 8'($urandom);
    port_ctl_in = 4'($urandom);
    port_st_in  = 5'($urandom);
    fd_out      = 10'($urandom);
    ded_in      = 5'($urandom);
    pwr_on      = 1'($urandom);
    reg_addr    = 2'($urandom);
    reg_wr      = 1'($urandom);
    reg_wdata   = 8'($urandom);
  endtask

  initial begin
    #200000;
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250611));
    n_chk = 0; n_err = 0;
    m_mode = 2'd0; m_hold = 8'h00;
    rst_n = 1'b0;
    cfg_mode = 2'b10; ovr_en = 1'b0; ovr_fd = 1'b0;
    randomize_pins();
    reg_wr = 1'b1; reg_addr = 2'd0;
    repeat (3) @(negedge clk);
    // Reset state: normal mode even though cfg asks for floppy (R1)
    check_all();
    rst_n = 1'b1;
    reg_wr = 1'b0;
    step();
    // Floppy mode 2 now; stored byte still the reset value (R6)
    reg_addr = 2'd0; reg_wr = 1'b0;
    check("R6", "hold after reset", {24'd0, reg_rdata}, 32'h0);
    step();
    // Same-cycle write and read in floppy mode (R6)
    cfg_mode = 2'b01; reg_addr = 2'd0; reg_wr = 1'b1; reg_wdata = 8'hA5;
    #2;
    check("R6", "read during write returns old", {24'd0, reg_rdata}, 32'h0);
    step();
    reg_wr = 1'b0;
    check("R6", "read after write", {24'd0, reg_rdata}, 32'hA5);
    // Power bit ignored in floppy mode 1 (R4)
    pwr_on = 1'b0; par_oe = 12'h000;
    step();
    // Override to floppy 2 while cfg says normal (R2), then override to normal
    cfg_mode = 2'b00; ovr_en = 1'b1; ovr_fd = 1'b1;
    step();
    check("R2", "override fd2", {30'd0, active_mode}, 32'd2);
    cfg_mode = 2'b10; ovr_fd = 1'b0;
    step();
    check("R2", "override normal", {30'd0, active_mode}, 32'd0);
    // Normal mode with power off (R3), code 11 decodes to normal (R1)
    ovr_en = 1'b0; cfg_mode = 2'b11; pwr_on = 1'b0; par_oe = 12'hFFF;
    step();
    step();
    // Constrained random mix
    for (int it = 0; it < 2000; it++) begin
      randomize_pins();
      if ($urandom_range(0, 3) == 0) cfg_mode = 2'($urandom);
      ovr_en = ($urandom_range(0, 7) == 0);
      ovr_fd = 1'($urandom);
      step();
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule